// File: doc/BRIEF.md
# Floppy Track Write Capture and Commit Controller

This block sits between the serial write path of an emulated floppy drive and a track buffer held in memory. While the host holds its write request active and the drive is enabled, every bit-cell strobe stores the raw write bit, unchanged, at the current rotational bit position of the track. The bit position comes from an internal rotation counter that steps on every bit-cell strobe, wraps at the track length and runs whether or not anything is being written. An index input realigns it to zero.

The block does not write through to storage. It marks the track as pending from the first stored bit and raises a single commit request, carrying the track number, when any of four events happens: a full rotation of bit cells has elapsed since the first stored bit, the write request is released, the drive is disabled, or the host steps to another track while data is pending. The storage side answers with an acknowledge; only then is the pending mark cleared and capture may start again, on whatever track is current at that point.

Top module: `tcap_top`

## Requirements
- R1: After reset the commit request is low, the buffer write enable is low and the buffer address (the rotation position) is 0.
- R2: The buffer address advances by one on every bit-cell strobe and wraps from TRACK_BITS-1 to 0, whether or not a write is active.
- R3: An index pulse sets the rotation position to 0 on the next clock, taking precedence over a bit-cell strobe in the same cycle.
- R4: On a bit-cell strobe with drive enable high, the write request low (active) and no commit outstanding, the buffer write enable is high in that cycle, the buffer data equals the serial write bit and the buffer address equals the rotation position.
- R5: No buffer write occurs while the write request is high (inactive) or the drive enable is low.
- R6: Counting the first stored bit as one, the strobe that completes TRACK_BITS strobes still writes its bit, and the commit request is high on the next clock.
- R7: While data is pending, releasing the write request (driving it high) raises the commit request on the next clock.
- R8: While data is pending, dropping the drive enable raises the commit request on the next clock.
- R9: While data is pending, a change of the track number raises the commit request on the next clock carrying the previous track number; the strobe in the cycle of the change and all strobes until the acknowledge store nothing.
- R10: The commit request and its track number stay unchanged until the acknowledge is seen; the request is low on the clock after the acknowledge, and the next capture latches the track number current at its first stored bit.
- R11: When several commit events occur in the same cycle, the commit request rises once and a single acknowledge retires it.
- R12: Without a stored bit, no event raises a commit request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req_n | input | 1 | Host write request, active low |
| drive_en | input | 1 | Drive enabled, active high |
| wr_bit | input | 1 | Serial write data bit |
| bit_stb | input | 1 | One-cycle bit-cell strobe |
| rot_index | input | 1 | Realign rotation position to 0 |
| track_num | input | TRK_W | Current head track number |
| commit_ack | input | 1 | Storage side has taken the commit |
| buf_we | output | 1 | Track buffer write enable |
| buf_addr | output | POS_W | Track buffer bit address (rotation position) |
| buf_din | output | 1 | Track buffer write bit |
| commit_req | output | 1 | Commit request, held until acknowledged |
| commit_track | output | TRK_W | Track number of the pending commit |

## Verification
The bench builds the block with a 64-cell track and 6-bit track numbers instead of the full 53248-cell default. The short track lets a directed test run a complete rotation, stepping one cell at a time, so the exact strobe that completes a rotation and the position wrap from 63 to 0 are both checked at the ports. The small track number width still leaves room for distinct old and new track values when the head steps during a pending write.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CAPTURE = 2'd1,
    ST_COMMIT  = 2'd2
  } cap_state_e;

endpackage

// File: rtl/tcap_rot_pos.sv
module tcap_rot_pos #(
  parameter int unsigned TRACK_BITS = 53248,
  localparam int unsigned POS_W = $clog2(TRACK_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             rot_index,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(TRACK_BITS - 1);

  logic [POS_W-1:0] pos_nxt;
  logic             pos_en;

  always_comb begin
    pos_en  = rot_index | bit_stb;
    pos_nxt = pos;
    if (rot_index) begin
      pos_nxt = '0;
    end else if (bit_stb) begin
      pos_nxt = (pos == LAST_POS) ? '0 : pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (pos_en) begin
      pos <= pos_nxt;
    end
  end

  // R2: wrap at the end of the track
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !rot_index && pos == LAST_POS) |=> (pos == '0));

  // R2: single step otherwise
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !rot_index && pos != LAST_POS) |=> (pos == $past(pos) + 1'b1));

  // R3: index realigns
  a_r3_index: assert property (@(posedge clk) disable iff (!rst_n)
    rot_index |=> (pos == '0));

endmodule

// File: rtl/tcap_gate.sv
module tcap_gate
  import tcap_pkg::*;
#(
  parameter int unsigned TRACK_BITS = 53248,
  parameter int unsigned TRK_W      = 8,
  localparam int unsigned POS_W = $clog2(TRACK_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cap_state_e       state,
  input  logic             wr_req_n,
  input  logic             drive_en,
  input  logic             bit_stb,
  input  logic             wr_bit,
  input  logic [TRK_W-1:0] track_num,
  input  logic [TRK_W-1:0] trk_held,
  output logic             buf_we,
  output logic             buf_din,
  output logic             start_cap,
  output logic             trigger
);

  localparam logic [POS_W-1:0] LAST_CNT = POS_W'(TRACK_BITS - 1);

  logic             write_ok;
  logic             in_idle;
  logic             in_capture;
  logic             trk_moved;
  logic             rot_done;
  logic [POS_W-1:0] cell_cnt;
  logic [POS_W-1:0] cell_cnt_nxt;
  logic             cell_cnt_en;

  always_comb begin
    write_ok   = drive_en & ~wr_req_n;
    in_idle    = (state == ST_IDLE);
    in_capture = (state == ST_CAPTURE);
    trk_moved  = in_capture & (track_num != trk_held);
    buf_we     = bit_stb & write_ok & (in_idle | (in_capture & ~trk_moved));
    buf_din    = wr_bit;
    start_cap  = buf_we & in_idle;
    rot_done   = in_capture & bit_stb & (cell_cnt == LAST_CNT);
    trigger    = in_capture & (rot_done | ~write_ok | trk_moved);
  end

  always_comb begin
    cell_cnt_en  = start_cap | (in_capture & bit_stb);
    cell_cnt_nxt = cell_cnt;
    if (start_cap) begin
      cell_cnt_nxt = POS_W'(1);
    end else if (in_capture & bit_stb) begin
      cell_cnt_nxt = cell_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_cnt <= '0;
    end else if (cell_cnt_en) begin
      cell_cnt <= cell_cnt_nxt;
    end
  end

  // R6: a capture never outlives one rotation of cells
  a_r6_rotation_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (in_capture && bit_stb && cell_cnt == LAST_CNT) |=> (state == ST_COMMIT));

endmodule

// File: rtl/tcap_fsm.sv
module tcap_fsm
  import tcap_pkg::*;
#(
  parameter int unsigned TRK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_cap,
  input  logic             trigger,
  input  logic             commit_ack,
  input  logic [TRK_W-1:0] track_num,
  output cap_state_e       state,
  output logic [TRK_W-1:0] trk_held,
  output logic             commit_req
);

  cap_state_e state_nxt;
  logic       trk_en;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:    if (start_cap)  state_nxt = ST_CAPTURE;
      ST_CAPTURE: if (trigger)    state_nxt = ST_COMMIT;
      ST_COMMIT:  if (commit_ack) state_nxt = ST_IDLE;
      default:                    state_nxt = ST_IDLE;
    endcase
    trk_en     = start_cap;
    commit_req = (state == ST_COMMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= state_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_held <= '0;
    end else if (trk_en) begin
      trk_held <= track_num;
    end
  end

  // R10: request and track held until acknowledged
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && !commit_ack) |=> (commit_req && $stable(trk_held)));

  // R10: request retires after acknowledge
  a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && commit_ack) |=> !commit_req);

  // R12: a request only follows a capture
  a_r12_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_req) |-> ($past(state) == ST_CAPTURE));

endmodule

// File: rtl/tcap_top.sv
module tcap_top
  import tcap_pkg::*;
#(
  parameter int unsigned TRACK_BITS = 53248,
  parameter int unsigned TRK_W      = 8,
  localparam int unsigned POS_W = $clog2(TRACK_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req_n,
  input  logic             drive_en,
  input  logic             wr_bit,
  input  logic             bit_stb,
  input  logic             rot_index,
  input  logic [TRK_W-1:0] track_num,
  input  logic             commit_ack,
  output logic             buf_we,
  output logic [POS_W-1:0] buf_addr,
  output logic             buf_din,
  output logic             commit_req,
  output logic [TRK_W-1:0] commit_track
);

  cap_state_e       state;
  logic [TRK_W-1:0] trk_held;
  logic             start_cap;
  logic             trigger;

  tcap_rot_pos #(
    .TRACK_BITS (TRACK_BITS)
  ) u_rot_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .rot_index (rot_index),
    .pos       (buf_addr)
  );

  tcap_gate #(
    .TRACK_BITS (TRACK_BITS),
    .TRK_W      (TRK_W)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .wr_req_n  (wr_req_n),
    .drive_en  (drive_en),
    .bit_stb   (bit_stb),
    .wr_bit    (wr_bit),
    .track_num (track_num),
    .trk_held  (trk_held),
    .buf_we    (buf_we),
    .buf_din   (buf_din),
    .start_cap (start_cap),
    .trigger   (trigger)
  );

  tcap_fsm #(
    .TRK_W (TRK_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_cap  (start_cap),
    .trigger    (trigger),
    .commit_ack (commit_ack),
    .track_num  (track_num),
    .state      (state),
    .trk_held   (trk_held),
    .commit_req (commit_req)
  );

  assign commit_track = trk_held;

  // R9: nothing is stored while a commit is outstanding
  a_r9_no_write_in_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> !buf_we);

  // R5: writes only under an active, enabled write
  a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_n || !drive_en) |-> !buf_we);

  // R7: release of the write request while pending leads to a commit
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAPTURE && wr_req_n) |=> commit_req);

endmodule

// File: tb/tcap_top_bench.sv
module tcap_top_bench;

  localparam int unsigned TB_BITS = 64;
  localparam int unsigned TB_TRK  = 6;
  localparam int unsigned TB_POSW = $clog2(TB_BITS);

  logic               clk;
  logic               rst_n;
  logic               wr_req_n;
  logic               drive_en;
  logic               wr_bit;
  logic               bit_stb;
  logic               rot_index;
  logic [TB_TRK-1:0]  track_num;
  logic               commit_ack;
  logic               buf_we;
  logic [TB_POSW-1:0] buf_addr;
  logic               buf_din;
  logic               commit_req;
  logic [TB_TRK-1:0]  commit_track;

  int checks;
  int failures;
  bit done;

  tcap_top #(
    .TRACK_BITS (TB_BITS),
    .TRK_W      (TB_TRK)
  ) u_tcap_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_req_n     (wr_req_n),
    .drive_en     (drive_en),
    .wr_bit       (wr_bit),
    .bit_stb      (bit_stb),
    .rot_index    (rot_index),
    .track_num    (track_num),
    .commit_ack   (commit_ack),
    .buf_we       (buf_we),
    .buf_addr     (buf_addr),
    .buf_din      (buf_din),
    .commit_req   (commit_req),
    .commit_track (commit_track)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // one strobe; checks the combinational write port before the edge
  task automatic strobe(input logic b, input logic exp_we, input string req);
    bit_stb = 1'b1;
    wr_bit  = b;
    #1;
    chk(buf_we == exp_we, req, buf_we, exp_we);
    if (exp_we) chk(buf_din == b, req, buf_din, b);
    tick();
    bit_stb = 1'b0;
  endtask

  task automatic do_ack();
    commit_ack = 1'b1;
    tick();
    commit_ack = 1'b0;
    chk(commit_req == 1'b0, "R10", commit_req, 0);
  endtask

  task automatic realign();
    rot_index = 1'b1;
    tick();
    rot_index = 1'b0;
  endtask

  task automatic t_reset();
    chk(commit_req == 1'b0, "R1", commit_req, 0);
    chk(buf_we == 1'b0, "R1", buf_we, 0);
    chk(buf_addr == '0, "R1", buf_addr, 0);
  endtask

  task automatic t_position();
    for (int i = 0; i < 10; i++) strobe(1'b1, 1'b0, "R5");
    chk(buf_addr == 10, "R2", buf_addr, 10);
    for (int i = 10; i < 63; i++) strobe(1'b0, 1'b0, "R5");
    chk(buf_addr == 63, "R2", buf_addr, 63);
    strobe(1'b0, 1'b0, "R5");
    chk(buf_addr == 0, "R2", buf_addr, 0);
    strobe(1'b0, 1'b0, "R5");
    strobe(1'b0, 1'b0, "R5");
    rot_index = 1'b1;
    bit_stb   = 1'b1;
    tick();
    rot_index = 1'b0;
    bit_stb   = 1'b0;
    chk(buf_addr == 0, "R3", buf_addr, 0);
    chk(commit_req == 1'b0, "R12", commit_req, 0);
  endtask

  task automatic t_release();
    realign();
    track_num = 6'd5;
    drive_en  = 1'b1;
    wr_req_n  = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(buf_addr == i, "R4", buf_addr, i);
      strobe(logic'(i[0]), 1'b1, "R4");
    end
    chk(commit_req == 1'b0, "R7", commit_req, 0);
    wr_req_n = 1'b1;
    tick();
    chk(commit_req == 1'b1, "R7", commit_req, 1);
    chk(commit_track == 5, "R7", commit_track, 5);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(commit_req == 1'b1, "R10", commit_req, 1);
      chk(commit_track == 5, "R10", commit_track, 5);
    end
    do_ack();
  endtask

  task automatic t_rotation();
    realign();
    strobe(1'b0, 1'b0, "R5");
    strobe(1'b0, 1'b0, "R5");
    strobe(1'b0, 1'b0, "R5");
    track_num = 6'd12;
    wr_req_n  = 1'b0;
    for (int i = 0; i < 63; i++) strobe(1'b1, 1'b1, "R6");
    chk(commit_req == 1'b0, "R6", commit_req, 0);
    #1;
    chk(buf_addr == 2, "R6", buf_addr, 2);
    strobe(1'b0, 1'b1, "R6");
    chk(commit_req == 1'b1, "R6", commit_req, 1);
    chk(commit_track == 12, "R6", commit_track, 12);
    strobe(1'b1, 1'b0, "R9");
    do_ack();
    wr_req_n = 1'b1;
    tick();
  endtask

  task automatic t_drive_off();
    track_num = 6'd20;
    wr_req_n  = 1'b0;
    strobe(1'b1, 1'b1, "R4");
    strobe(1'b0, 1'b1, "R4");
    drive_en = 1'b0;
    tick();
    chk(commit_req == 1'b1, "R8", commit_req, 1);
    chk(commit_track == 20, "R8", commit_track, 20);
    do_ack();
    strobe(1'b1, 1'b0, "R5");
    tick();
    chk(commit_req == 1'b0, "R12", commit_req, 0);
    wr_req_n = 1'b1;
    drive_en = 1'b1;
    tick();
  endtask

  task automatic t_track_change();
    track_num = 6'd7;
    wr_req_n  = 1'b0;
    strobe(1'b1, 1'b1, "R4");
    strobe(1'b1, 1'b1, "R4");
    track_num = 6'd9;
    strobe(1'b1, 1'b0, "R9");
    chk(commit_req == 1'b1, "R9", commit_req, 1);
    chk(commit_track == 7, "R9", commit_track, 7);
    strobe(1'b0, 1'b0, "R9");
    strobe(1'b1, 1'b0, "R9");
    do_ack();
    strobe(1'b1, 1'b1, "R10");
    wr_req_n = 1'b1;
    tick();
    chk(commit_req == 1'b1, "R10", commit_req, 1);
    chk(commit_track == 9, "R10", commit_track, 9);
    do_ack();
  endtask

  task automatic t_multi();
    int rises;
    logic prev;
    track_num = 6'd30;
    wr_req_n  = 1'b0;
    drive_en  = 1'b1;
    strobe(1'b1, 1'b1, "R4");
    wr_req_n  = 1'b1;
    drive_en  = 1'b0;
    track_num = 6'd31;
    rises = 0;
    prev  = commit_req;
    tick();
    if (commit_req && !prev) rises++;
    chk(commit_track == 30, "R11", commit_track, 30);
    prev = commit_req;
    tick();
    if (commit_req && !prev) rises++;
    do_ack();
    for (int i = 0; i < 6; i++) begin
      tick();
      if (commit_req) rises++;
    end
    chk(rises == 1, "R11", rises, 1);
    drive_en = 1'b1;
  endtask

  task automatic t_no_write();
    for (int i = 0; i < 4; i++) begin
      wr_req_n = ~wr_req_n;
      drive_en = ~drive_en;
      tick();
    end
    wr_req_n  = 1'b0;
    drive_en  = 1'b1;
    track_num = 6'd3;
    tick();
    track_num = 6'd4;
    tick();
    chk(commit_req == 1'b0, "R12", commit_req, 0);
    wr_req_n = 1'b1;
    tick();
  endtask

  initial begin
    checks     = 0;
    failures   = 0;
    done       = 1'b0;
    rst_n      = 1'b0;
    wr_req_n   = 1'b1;
    drive_en   = 1'b1;
    wr_bit     = 1'b0;
    bit_stb    = 1'b0;
    rot_index  = 1'b0;
    track_num  = '0;
    commit_ack = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_position();
    t_release();
    t_rotation();
    t_drive_off();
    t_track_change();
    t_multi();
    t_no_write();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule